// File: doc/BRIEF.md
# Serial Bus Control and Status Register

This block is the host-facing control and status register of a two-wire serial bus interface. The host writes it to force a bus release (data output latch to 1) or a command condition (data output latch to 0), and to arm a single acknowledge pulse. The host reads it to see whether a release condition or a command condition has been observed on the bus lines.

The serial clock and data inputs are asynchronous. Each passes through a two-flop synchronizer, and a history stage after that finds edges. The shift register, the clock generator and the address comparator live elsewhere. They appear here only as a transfer-start strobe and an address-mismatch strobe. A data output port combines the output latch with the acknowledge drive.

Top module: `sbus_ctl_reg`

## Requirements
- R1: After reset, `rd_data` is 0x00, `sda_out` is 1 and `ack_active` is 0.
- R2: Bit 7 (bus-busy enable) and bit 5 (acknowledge enable) are plain storage bits. A write stores them and a read returns them, whatever the interface enable is.
- R3: Bits 2, 3 and 6 are read-only, and writes to them have no effect. Bit 6 always reads 0.
- R4: A write with bit 0 (release trigger) set while `if_en` is 1 sets the data output latch to 1 on the following cycle. Bits 0, 1 and 4 always read 0.
- R5: A write with bit 1 (command trigger) set and bit 0 clear while `if_en` is 1 clears the latch to 0. If bits 0 and 1 are both set, the latch becomes 1.
- R6: While `if_en` is 0, the trigger bits have no effect on the latch, both detection flags are cleared, and a pending or active acknowledge is dropped.
- R7: A rising edge on `sda_in` while `scl_in` is steadily high sets bit 2 (release flag) within four clock cycles. Detection works on the synchronized lines.
- R8: A falling edge on `sda_in` while `scl_in` is high sets bit 3 (command flag). A release detection clears bit 3, and release wins when both would happen together.
- R9: `xfer_start` clears both flags. `addr_miss` clears the release flag only.
- R10: When a set and a clear of the same flag fall in the same cycle, the flag ends at 1.
- R11: A write with bit 4 set while enabled arms one acknowledge. At the next synchronized falling edge of `scl_in`, `ack_active` rises and `sda_out` is held at 0. Both return at the next rising edge of `scl_in`. One write produces only one pulse.
- R12: `xfer_start` cancels an armed acknowledge that has not yet started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| if_en | input | 1 | Interface enable |
| xfer_start | input | 1 | Transfer-start strobe from the shift logic |
| addr_miss | input | 1 | Address-mismatch strobe after an address byte |
| sda_out | output | 1 | Data output: latch value, forced to 0 during acknowledge |
| ack_active | output | 1 | High while the acknowledge is driven |

## Verification
The in-line assertions check these properties on every cycle:
- the latch response to each trigger write;
- that the latch holds still while disabled;
- the clearing of both flags, including release taking priority over command;
- that an acknowledge always pulls the data output low and starts on a clock fall once armed.

Only the bench's scenarios show the end-to-end timing through the synchronizers:
- that line edges really become flags;
- that a set beats a coinciding clear;
- that an acknowledge is a one-shot bounded by the serial clock's low phase;
- that a transfer start cancels it.

// File: rtl/sbus_ctl_pkg.sv
// Package: bit positions of the control/status register and the bus event
// bundle passed from the condition detector to the register logic.
package sbus_ctl_pkg;
    localparam int REG_W        = 8;
    localparam int BIT_REL_TRIG = 0;
    localparam int BIT_CMD_TRIG = 1;
    localparam int BIT_REL_FLAG = 2;
    localparam int BIT_CMD_FLAG = 3;
    localparam int BIT_ACK_REQ  = 4;
    localparam int BIT_ACK_EN   = 5;
    localparam int BIT_ACK_SEEN = 6;
    localparam int BIT_BUSY_EN  = 7;

    typedef struct packed {
        logic rel;       // data rose while clock high
        logic cmd;       // data fell while clock high
        logic scl_fall;  // serial clock falling edge
        logic scl_rise;  // serial clock rising edge
    } bus_evt_t;
endpackage

// File: rtl/sbus_sync.sv
// Multi-stage synchronizer for WIDTH asynchronous lines.
// Assumes: inputs are level signals; reset value models an idle (high) bus.
module sbus_sync #(
    parameter int STAGES    = 2,
    parameter int WIDTH     = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] pipe [STAGES];

    // First stage captures the asynchronous lines.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= {WIDTH{RST_VAL}};
        else        pipe[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-registers the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[s] <= {WIDTH{RST_VAL}};
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/sbus_cond_det.sv
// Bus condition detector: finds release (data rising, clock high), command
// (data falling, clock high) and serial clock edges on synchronized lines.
// Assumes: inputs are already synchronized; events are gated by enable.
module sbus_cond_det
    import sbus_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_h, sda_h;

    // History stage: line values one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_h <= 1'b1;
            sda_h <= 1'b1;
        end else begin
            scl_h <= scl_s;
            sda_h <= sda_s;
        end
    end

    // Edge classification; the clock must be high on both samples.
    always_comb begin
        evt.rel      = enable && scl_s && scl_h && sda_s && !sda_h;
        evt.cmd      = enable && scl_s && scl_h && !sda_s && sda_h;
        evt.scl_fall = enable && scl_h && !scl_s;
        evt.scl_rise = enable && !scl_h && scl_s;
    end

    // R8: the two data conditions can never coincide.
    a_r8_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.rel && evt.cmd));
endmodule

// File: rtl/sbus_ack_gen.sv
// Acknowledge generator: a host request arms one pulse, which starts at the
// next serial clock fall and ends at the following rise.
// Assumes: arm is a single-cycle write strobe, already gated by enable.
module sbus_ack_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic if_en,
    input  logic arm,
    input  logic cancel,
    input  logic scl_fall,
    input  logic scl_rise,
    output logic active
);
    logic pending;

    // Arm state: cancel wins, then a new request, then consumption at a fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pending <= 1'b0;
        else if (cancel || !if_en)    pending <= 1'b0;
        else if (arm)                 pending <= 1'b1;
        else if (scl_fall)            pending <= 1'b0;
    end

    // Drive state: starts on a fall while armed, ends on a rise or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        active <= 1'b0;
        else if (!if_en)                                   active <= 1'b0;
        else if (pending && scl_fall && !cancel && !arm)   active <= 1'b1;
        else if (scl_rise)                                 active <= 1'b0;
    end

    // R11: an armed request is turned into a pulse at the clock fall.
    a_r11_ack_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && scl_fall && !cancel && !arm && if_en) |=> active);
    // R12: a cancel leaves nothing armed.
    a_r12_cancel_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !pending);
    // R11: the pulse is released at a clock rise.
    a_r11_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (active && scl_rise) |=> !active);
endmodule

// File: rtl/sbus_ctl_reg.sv
// Serial bus control/status register. Holds the two storage bits, the
// release and command detection flags and the data output latch, and
// combines the latch with the acknowledge drive.
// Assumes: wr_en is a single-cycle strobe; scl_in/sda_in are asynchronous.
module sbus_ctl_reg
    import sbus_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             if_en,
    input  logic             xfer_start,
    input  logic             addr_miss,
    output logic             sda_out,
    output logic             ack_active
);
    logic [1:0] lines_s;
    bus_evt_t   evt;
    logic       busy_en, ack_en, rel_flag, cmd_flag, so_latch;
    logic       rel_hit, cmd_hit, ack_arm;

    sbus_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({scl_in, sda_in}),
        .q_sync  (lines_s)
    );

    sbus_cond_det u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (if_en),
        .scl_s  (lines_s[1]),
        .sda_s  (lines_s[0]),
        .evt    (evt)
    );

    // Write strobes for the self-clearing triggers, gated by the enable.
    always_comb begin
        rel_hit = wr_en && if_en && wr_data[BIT_REL_TRIG];
        cmd_hit = wr_en && if_en && wr_data[BIT_CMD_TRIG];
        ack_arm = wr_en && if_en && wr_data[BIT_ACK_REQ];
    end

    sbus_ack_gen u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .if_en    (if_en),
        .arm      (ack_arm),
        .cancel   (xfer_start),
        .scl_fall (evt.scl_fall),
        .scl_rise (evt.scl_rise),
        .active   (ack_active)
    );

    // Plain storage bits, writable whatever the enable is.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_en <= 1'b0;
            ack_en  <= 1'b0;
        end else if (wr_en) begin
            busy_en <= wr_data[BIT_BUSY_EN];
            ack_en  <= wr_data[BIT_ACK_EN];
        end
    end

    // Data output latch: release trigger wins over command trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)       so_latch <= 1'b1;
        else if (rel_hit) so_latch <= 1'b1;
        else if (cmd_hit) so_latch <= 1'b0;
    end

    // Release flag: set wins over its clear sources.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rel_flag <= 1'b0;
        else if (evt.rel)                            rel_flag <= 1'b1;
        else if (xfer_start || addr_miss || !if_en)  rel_flag <= 1'b0;
    end

    // Command flag: a release clears it; otherwise set wins over clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cmd_flag <= 1'b0;
        else if (evt.rel)                 cmd_flag <= 1'b0;
        else if (evt.cmd)                 cmd_flag <= 1'b1;
        else if (xfer_start || !if_en)    cmd_flag <= 1'b0;
    end

    // Read assembly: trigger bits and the unused detect bit read 0.
    always_comb begin
        rd_data               = '0;
        rd_data[BIT_BUSY_EN]  = busy_en;
        rd_data[BIT_ACK_EN]   = ack_en;
        rd_data[BIT_CMD_FLAG] = cmd_flag;
        rd_data[BIT_REL_FLAG] = rel_flag;
    end

    // Output pin: acknowledge pulls the line low over the latch value.
    assign sda_out = so_latch && !ack_active;

    a_r4_rel_trig_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && if_en && wr_data[BIT_REL_TRIG]) |=> so_latch);
    a_r5_cmd_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && if_en && wr_data[BIT_CMD_TRIG] && !wr_data[BIT_REL_TRIG])
        |=> !so_latch);
    a_r6_disabled_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en |=> $stable(so_latch));
    a_r6_disabled_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en |=> (!rel_flag && !cmd_flag));
    a_r9_rel_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_start || addr_miss) && !evt.rel) |=> !rel_flag);
    a_r8_rel_clears_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        evt.rel |=> (!cmd_flag && rel_flag));
    a_r11_ack_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
        ack_active |-> !sda_out);
    always_comb begin
        a_r3_unused_bit_zero: assert (rd_data[BIT_ACK_SEEN] == 1'b0);
    end
endmodule

// File: tb/test_sbus_ctl_reg.sv
module test_sbus_ctl_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, scl_in, sda_in, if_en, xfer_start, addr_miss;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       sda_out, ack_active;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    sbus_ctl_reg i_sbus_ctl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .scl_in(scl_in), .sda_in(sda_in), .if_en(if_en),
        .xfer_start(xfer_start), .addr_miss(addr_miss),
        .sda_out(sda_out), .ack_active(ack_active)
    );

    function automatic logic [7:0] exp_rd(logic busy, logic acke, logic cmdf, logic relf);
        return {busy, 1'b0, acke, 1'b0, cmdf, relf, 2'b00};
    endfunction

    function automatic logic exp_latch(logic prev, logic [7:0] d, logic en);
        if (!en)  return prev;
        if (d[0]) return 1'b1;
        if (d[1]) return 1'b0;
        return prev;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_data = d; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_xfer();
        xfer_start = 1'b1; cyc(1); xfer_start = 1'b0;
    endtask

    initial begin
        logic busy, acke, lat;
        void'($urandom(32'd20240613));
        rst_n = 0; wr_en = 0; wr_data = 0; scl_in = 1; sda_in = 1;
        if_en = 1; xfer_start = 0; addr_miss = 0;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 8'h00);
        chk(sda_out == 1'b1 && ack_active == 1'b0, "R1 outputs",
            {sda_out, ack_active}, 2'b10);

        // R2 R3 R4 R5 R6: random writes with stable lines
        busy = 0; acke = 0; lat = 1;
        for (int i = 0; i < 60; i++) begin
            logic [7:0] d;
            logic en;
            d  = 8'($urandom);
            en = 1'($urandom);
            if_en = en;
            wr(d);
            busy = d[7]; acke = d[5];
            lat  = exp_latch(lat, d, en);
            chk(rd_data == exp_rd(busy, acke, 1'b0, 1'b0),
                "R2/R3/R4 readback", rd_data, exp_rd(busy, acke, 1'b0, 1'b0));
            chk(sda_out == lat, en ? "R5 latch" : "R6 latch held", sda_out, lat);
        end
        if_en = 1; pulse_xfer();
        wr(8'h00);

        // R5 directed: both triggers -> 1
        wr(8'h02); chk(sda_out == 0, "R5 cmd trigger", sda_out, 0);
        wr(8'h03); chk(sda_out == 1, "R5 both triggers", sda_out, 1);
        wr(8'h02);
        if_en = 0; wr(8'h01); if_en = 1;
        chk(sda_out == 0, "R6 release trigger ignored", sda_out, 0);
        wr(8'h01);
        chk(sda_out == 1, "R4 release trigger", sda_out, 1);

        // R8 command detect
        sda_in = 0; cyc(5);
        chk(rd_data[3:2] == 2'b10, "R8 command flag", rd_data[3:2], 2'b10);
        // R3 write to read-only bits ignored
        wr(8'h4C);
        chk(rd_data == 8'h08, "R3 read-only ignored", rd_data, 8'h08);
        // R7 release detect, R8 release clears command
        sda_in = 1; cyc(5);
        chk(rd_data[3:2] == 2'b01, "R7/R8 release flag", rd_data[3:2], 2'b01);
        // R9 xfer_start clears release
        pulse_xfer();
        chk(rd_data[3:2] == 2'b00, "R9 xfer clears release", rd_data[3:2], 2'b00);
        sda_in = 0; cyc(5);
        pulse_xfer();
        chk(rd_data[3:2] == 2'b00, "R9 xfer clears command", rd_data[3:2], 2'b00);
        sda_in = 1; cyc(5);
        addr_miss = 1; cyc(1); addr_miss = 0;
        chk(rd_data[3:2] == 2'b00, "R9 addr_miss clears release", rd_data[3:2], 2'b00);
        // R9 addr_miss leaves command flag alone
        sda_in = 0; cyc(5);
        addr_miss = 1; cyc(1); addr_miss = 0;
        chk(rd_data[3:2] == 2'b10, "R9 addr_miss keeps command", rd_data[3:2], 2'b10);
        // R10 set wins: raise sda, clear coincides with the detection edge
        sda_in = 1; cyc(2);
        xfer_start = 1; cyc(1); xfer_start = 0;
        chk(rd_data[2] == 1, "R10 set beats clear", rd_data[2], 1);
        // R6 disable clears flags
        if_en = 0; cyc(1);
        chk(rd_data[3:2] == 2'b00, "R6 disable clears flags", rd_data[3:2], 2'b00);
        if_en = 1; cyc(1);

        // R11 acknowledge
        wr(8'h11);
        chk(rd_data[4] == 0, "R11 request reads 0", rd_data[4], 0);
        scl_in = 0; cyc(4);
        chk(ack_active == 1 && sda_out == 0, "R11 ack driven",
            {ack_active, sda_out}, 2'b10);
        scl_in = 1; cyc(4);
        chk(ack_active == 0 && sda_out == 1, "R11 ack released",
            {ack_active, sda_out}, 2'b01);
        scl_in = 0; cyc(4);
        chk(ack_active == 0, "R11 one-shot", ack_active, 0);
        scl_in = 1; cyc(4);
        // R12 cancel before clock fall
        wr(8'h10); pulse_xfer();
        scl_in = 0; cyc(4);
        chk(ack_active == 0, "R12 cancelled ack", ack_active, 0);
        scl_in = 1; cyc(4);
        // R6 disable drops active ack
        wr(8'h10); scl_in = 0; cyc(4);
        chk(ack_active == 1, "R11 ack again", ack_active, 1);
        if_en = 0; cyc(1);
        chk(ack_active == 0, "R6 disable drops ack", ack_active, 0);
        if_en = 1; scl_in = 1; cyc(4);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule